// File: doc/BRIEF.md
# DMA Channel Interrupt Aggregator

This block gathers the per-channel interrupt events of an eight-channel DMA engine into two interrupt classes. The error class collects events raised when a data transfer on a channel receives an error response from the bus. The completion class collects terminal-count events raised when a channel's transfer count reaches zero. For each class the block holds a sticky raw status vector that ignores masking. It also derives a masked view using per-channel enable bits taken from each channel's configuration, where the error and completion enables are independent.

Three registered, active-high interrupt lines leave the block: one per class and a combined request that is the OR of the two. The combined line suits a system with few interrupt controller inputs. Software then locates the source through a per-channel summary register, which shows every channel with any masked interrupt pending, and through the raw and masked status registers. Each class is acknowledged through its own write-one-to-clear register.

Top module: `dma_irq_agg`

## Requirements
- R1: After reset every raw status bit, `rd_data_o` and all three interrupt outputs are 0.
- R2: A 1 on `err_event_i[c]` sets raw error bit c at the clock edge that samples it. The bit then holds until it is cleared.
- R3: A 1 on `tc_event_i[c]` sets raw completion bit c at the clock edge that samples it. The bit then holds until it is cleared.
- R4: The raw status registers (address 4 = raw error, address 2 = raw completion; bit c = channel c) report recorded events whatever the enable bits are.
- R5: The masked status registers (address 3 = masked error, address 1 = masked completion) equal the raw vector ANDed with `err_enable_i` or `tc_enable_i` respectively.
- R6: `irq_err_o` is the OR of the masked error bits. It is registered and computed from the status and enables in force after the same edge that updates the status.
- R7: `irq_tc_o` is the OR of the masked completion bits, with the same timing as R6.
- R8: `irq_any_o` equals `irq_err_o` OR `irq_tc_o` in every cycle.
- R9: Address 0 reads the per-channel summary: bit c is masked error bit c OR masked completion bit c.
- R10: A write (`wr_en_i`=1) to address 5 clears every raw completion bit whose `wr_data_i` bit is 1. Data bits of 0 leave their bits unchanged, and the error status is untouched.
- R11: A write to address 6 clears every raw error bit whose `wr_data_i` bit is 1. Data bits of 0 leave their bits unchanged, and the completion status is untouched.
- R12: When an event and a clear hit the same channel bit in the same cycle, the bit ends up set.
- R13: `rd_data_o` is registered. It shows, one edge after `rd_addr_i` is presented, the register contents from before that edge. Addresses 5, 6 and 7 read 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| err_event_i | input | 8 | Per-channel bus-error event pulses |
| tc_event_i | input | 8 | Per-channel terminal-count event pulses |
| err_enable_i | input | 8 | Per-channel error interrupt enables |
| tc_enable_i | input | 8 | Per-channel completion interrupt enables |
| wr_en_i | input | 1 | Register write strobe |
| wr_addr_i | input | 3 | Register write address |
| wr_data_i | input | 8 | Register write data, one bit per channel |
| rd_addr_i | input | 3 | Register read address, sampled every cycle |
| rd_data_o | output | 8 | Registered read data |
| irq_err_o | output | 1 | Error interrupt |
| irq_tc_o | output | 1 | Completion interrupt |
| irq_any_o | output | 1 | Combined interrupt |

## Verification
Events, clears and enable changes show up on the three interrupt lines at the very edge that samples them, with no added delay. Read data appears one edge after the address and reflects the state from before that edge. For each stimulus cycle, the driver task works out both results from a bench model of the requirements. It queues them as tagged items marked due one cycle later. The monitor compares each item on the falling edge after that due edge, so every sample is taken half a period away from the edge that produced it.

// File: rtl/dma_irq_pkg.sv
package dma_irq_pkg;

    localparam int ADDR_W    = 3;
    localparam int NUM_CLASS = 2;

    // class indices for the status banks
    localparam int CLS_ERR = 0;
    localparam int CLS_TC  = 1;

    // register map
    localparam logic [ADDR_W-1:0] ADDR_SUMMARY = 3'd0;
    localparam logic [ADDR_W-1:0] ADDR_TC_MSK  = 3'd1;
    localparam logic [ADDR_W-1:0] ADDR_TC_RAW  = 3'd2;
    localparam logic [ADDR_W-1:0] ADDR_ERR_MSK = 3'd3;
    localparam logic [ADDR_W-1:0] ADDR_ERR_RAW = 3'd4;
    localparam logic [ADDR_W-1:0] ADDR_TC_CLR  = 3'd5;
    localparam logic [ADDR_W-1:0] ADDR_ERR_CLR = 3'd6;

    function automatic logic [ADDR_W-1:0] clear_addr(input int cls);
        return (cls == CLS_ERR) ? ADDR_ERR_CLR : ADDR_TC_CLR;
    endfunction

endpackage

// File: rtl/irq_status_bank.sv
module irq_status_bank #(
    parameter int NUM_CH = 8
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic [NUM_CH-1:0] event_i,
    input  logic [NUM_CH-1:0] clear_i,
    input  logic [NUM_CH-1:0] enable_i,
    output logic [NUM_CH-1:0] raw_o,
    output logic [NUM_CH-1:0] masked_o,
    output logic [NUM_CH-1:0] masked_next_o,
    output logic              irq_o
);

    typedef struct packed {
        logic [NUM_CH-1:0] raw;
        logic              irq;
    } bank_state_t;

    bank_state_t       state_d, state_q;
    logic [NUM_CH-1:0] raw_next;

    // per channel: clear first, then a same-cycle event sets the bit again
    for (genvar ch = 0; ch < NUM_CH; ch++) begin : g_bit
        always_comb begin
            raw_next[ch] = event_i[ch] | (state_q.raw[ch] & ~clear_i[ch]);
        end
    end

    always_comb begin
        state_d       = state_q;
        state_d.raw   = raw_next;
        masked_next_o = raw_next & enable_i;
        state_d.irq   = |masked_next_o;
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            state_q <= '0;
        end else begin
            state_q <= state_d;
        end
    end

    assign raw_o    = state_q.raw;
    assign masked_o = state_q.raw & enable_i;
    assign irq_o    = state_q.irq;

    // R12
    event_wins_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (event_i != '0) |=> ((raw_o & $past(event_i)) == $past(event_i)));

    // R10
    clear_applies_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        ((clear_i & ~event_i) != '0) |=> ((raw_o & $past(clear_i & ~event_i)) == '0));

    // R2
    status_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (event_i == '0 && clear_i == '0) |=> $stable(raw_o));

    // R6
    irq_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (raw_o == '0) |-> !irq_o);

endmodule

// File: rtl/irq_read_mux.sv
module irq_read_mux
    import dma_irq_pkg::*;
#(
    parameter int NUM_CH = 8
) (
    input  logic [ADDR_W-1:0] addr_i,
    input  logic [NUM_CH-1:0] err_raw_i,
    input  logic [NUM_CH-1:0] err_msk_i,
    input  logic [NUM_CH-1:0] tc_raw_i,
    input  logic [NUM_CH-1:0] tc_msk_i,
    output logic [NUM_CH-1:0] data_o
);

    always_comb begin
        data_o = '0;
        case (addr_i)
            ADDR_SUMMARY: data_o = err_msk_i | tc_msk_i;
            ADDR_TC_MSK:  data_o = tc_msk_i;
            ADDR_TC_RAW:  data_o = tc_raw_i;
            ADDR_ERR_MSK: data_o = err_msk_i;
            ADDR_ERR_RAW: data_o = err_raw_i;
            default:      data_o = '0;
        endcase
    end

endmodule

// File: rtl/dma_irq_agg.sv
module dma_irq_agg
    import dma_irq_pkg::*;
#(
    parameter int NUM_CH = 8
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic [NUM_CH-1:0] err_event_i,
    input  logic [NUM_CH-1:0] tc_event_i,
    input  logic [NUM_CH-1:0] err_enable_i,
    input  logic [NUM_CH-1:0] tc_enable_i,
    input  logic              wr_en_i,
    input  logic [ADDR_W-1:0] wr_addr_i,
    input  logic [NUM_CH-1:0] wr_data_i,
    input  logic [ADDR_W-1:0] rd_addr_i,
    output logic [NUM_CH-1:0] rd_data_o,
    output logic              irq_err_o,
    output logic              irq_tc_o,
    output logic              irq_any_o
);

    typedef struct packed {
        logic [NUM_CH-1:0] rd_data;
        logic              irq_any;
    } top_state_t;

    logic [NUM_CH-1:0] ev_a     [NUM_CLASS];
    logic [NUM_CH-1:0] en_a     [NUM_CLASS];
    logic [NUM_CH-1:0] clr_a    [NUM_CLASS];
    logic [NUM_CH-1:0] raw_a    [NUM_CLASS];
    logic [NUM_CH-1:0] msk_a    [NUM_CLASS];
    logic [NUM_CH-1:0] mnext_a  [NUM_CLASS];
    logic              irq_a    [NUM_CLASS];
    logic [NUM_CH-1:0] rd_mux;
    top_state_t        state_d, state_q;

    assign ev_a[CLS_ERR] = err_event_i;
    assign ev_a[CLS_TC]  = tc_event_i;
    assign en_a[CLS_ERR] = err_enable_i;
    assign en_a[CLS_TC]  = tc_enable_i;

    for (genvar cls = 0; cls < NUM_CLASS; cls++) begin : g_class
        always_comb begin
            clr_a[cls] = (wr_en_i && wr_addr_i == clear_addr(cls)) ? wr_data_i : '0;
        end

        irq_status_bank #(
            .NUM_CH (NUM_CH)
        ) i_bank (
            .clk_i         (clk_i),
            .rst_ni        (rst_ni),
            .event_i       (ev_a[cls]),
            .clear_i       (clr_a[cls]),
            .enable_i      (en_a[cls]),
            .raw_o         (raw_a[cls]),
            .masked_o      (msk_a[cls]),
            .masked_next_o (mnext_a[cls]),
            .irq_o         (irq_a[cls])
        );
    end

    irq_read_mux #(
        .NUM_CH (NUM_CH)
    ) i_read_mux (
        .addr_i    (rd_addr_i),
        .err_raw_i (raw_a[CLS_ERR]),
        .err_msk_i (msk_a[CLS_ERR]),
        .tc_raw_i  (raw_a[CLS_TC]),
        .tc_msk_i  (msk_a[CLS_TC]),
        .data_o    (rd_mux)
    );

    always_comb begin
        state_d         = state_q;
        state_d.rd_data = rd_mux;
        state_d.irq_any = (|mnext_a[CLS_ERR]) | (|mnext_a[CLS_TC]);
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            state_q <= '0;
        end else begin
            state_q <= state_d;
        end
    end

    assign rd_data_o = state_q.rd_data;
    assign irq_err_o = irq_a[CLS_ERR];
    assign irq_tc_o  = irq_a[CLS_TC];
    assign irq_any_o = state_q.irq_any;

    // R8
    any_is_or_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        irq_any_o == (irq_err_o || irq_tc_o));

    // R13
    clr_reads_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (rd_addr_i == ADDR_TC_CLR || rd_addr_i == ADDR_ERR_CLR || rd_addr_i == 3'd7)
        |=> (rd_data_o == '0));

    // R11
    err_clear_spares_tc_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (wr_en_i && wr_addr_i == ADDR_ERR_CLR && tc_event_i == '0) |=> $stable(raw_a[CLS_TC]));

endmodule

// File: tb/test_dma_irq_agg.sv
module test_dma_irq_agg;

    localparam int N = 8;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic [N-1:0] err_ev = '0, tc_ev = '0, err_en = '0, tc_en = '0;
    logic         wr_en = 1'b0;
    logic [2:0]   wr_addr = '0, rd_addr = '0;
    logic [N-1:0] wr_data = '0;
    logic [N-1:0] rd_data;
    logic         irq_err, irq_tc, irq_any;

    int checks = 0;
    int errors = 0;
    int cyc = 0;

    typedef struct {
        int           due;
        int           kind;
        logic [N-1:0] exp;
        string        tag;
    } item_t;

    item_t q[$];
    logic [N-1:0] m_err = '0, m_tc = '0;

    always #5 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    dma_irq_agg #(.NUM_CH(N)) i_dma_irq_agg (
        .clk_i(clk), .rst_ni(rst_n),
        .err_event_i(err_ev), .tc_event_i(tc_ev),
        .err_enable_i(err_en), .tc_enable_i(tc_en),
        .wr_en_i(wr_en), .wr_addr_i(wr_addr), .wr_data_i(wr_data),
        .rd_addr_i(rd_addr), .rd_data_o(rd_data),
        .irq_err_o(irq_err), .irq_tc_o(irq_tc), .irq_any_o(irq_any)
    );

    task automatic check(input string tag, input string what,
                         input logic [N-1:0] got, input logic [N-1:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s %s: got %h expected %h", tag, what, got, exp);
        end
    endtask

    function automatic logic [N-1:0] read_model(input logic [2:0] a,
                                               input logic [N-1:0] ee, input logic [N-1:0] te);
        case (a)
            3'd0: return (m_err & ee) | (m_tc & te);
            3'd1: return m_tc & te;
            3'd2: return m_tc;
            3'd3: return m_err & ee;
            3'd4: return m_err;
            default: return '0;
        endcase
    endfunction

    // driver: one cycle of stimulus, expected results queued as due next edge
    task automatic step(input logic [N-1:0] ee, input logic [N-1:0] te,
                        input logic [N-1:0] een, input logic [N-1:0] ten,
                        input logic we, input logic [2:0] wa, input logic [N-1:0] wd,
                        input logic [2:0] ra, input string tag);
        logic [N-1:0] clr_e, clr_t;
        item_t it;
        @(negedge clk);
        err_ev = ee; tc_ev = te; err_en = een; tc_en = ten;
        wr_en = we; wr_addr = wa; wr_data = wd; rd_addr = ra;
        it.due = cyc + 1; it.tag = tag;
        it.kind = 0; it.exp = read_model(ra, een, ten); q.push_back(it);
        clr_e = (we && wa == 3'd6) ? wd : '0;
        clr_t = (we && wa == 3'd5) ? wd : '0;
        m_err = (m_err & ~clr_e) | ee;
        m_tc  = (m_tc & ~clr_t) | te;
        it.kind = 1; it.exp = {{(N-1){1'b0}}, |(m_err & een)}; q.push_back(it);
        it.kind = 2; it.exp = {{(N-1){1'b0}}, |(m_tc & ten)}; q.push_back(it);
        it.kind = 3; it.exp = {{(N-1){1'b0}}, (|(m_err & een)) | (|(m_tc & ten))}; q.push_back(it);
    endtask

    task automatic rd(input logic [2:0] ra, input logic [N-1:0] een,
                      input logic [N-1:0] ten, input string tag);
        step('0, '0, een, ten, 1'b0, 3'd0, '0, ra, tag);
    endtask

    // monitor
    always @(negedge clk) begin
        while (q.size() > 0 && q[0].due <= cyc) begin
            item_t it;
            it = q.pop_front();
            case (it.kind)
                0: check(it.tag, "rd_data", rd_data, it.exp);
                1: check(it.tag, "irq_err", {{(N-1){1'b0}}, irq_err}, it.exp);
                2: check(it.tag, "irq_tc", {{(N-1){1'b0}}, irq_tc}, it.exp);
                default: check(it.tag, "irq_any", {{(N-1){1'b0}}, irq_any}, it.exp);
            endcase
        end
    end

    initial begin
        #2_000_000;
        errors++;
        $display("FAIL R1 watchdog: got timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1: reset state at the ports
        check("R1", "rd_data", rd_data, '0);
        check("R1", "irq_any", {{(N-1){1'b0}}, irq_any}, '0);
        for (int a = 0; a < 8; a++) rd(a[2:0], '1, '1, "R1");

        // R2 / R6: error event on channel 2, enables on
        step(8'h04, '0, '1, '1, 1'b0, 3'd0, '0, 3'd4, "R2");
        rd(3'd4, '1, '1, "R2");
        rd(3'd3, '1, '1, "R6");

        // R3 / R4 / R5: completion on channel 5 with its enable off
        step('0, 8'h20, '1, 8'hDF, 1'b0, 3'd0, '0, 3'd2, "R3");
        rd(3'd2, '1, 8'hDF, "R4");
        rd(3'd1, '1, 8'hDF, "R5");
        rd(3'd0, '1, 8'hDF, "R9");

        // R7: enabling the channel raises the completion line
        rd(3'd1, '1, '1, "R7");
        rd(3'd0, '1, '1, "R9");

        // R10: zero write, then clearing bit 5 plus an unset bit
        step('0, '0, '1, '1, 1'b1, 3'd5, 8'h00, 3'd2, "R10");
        step('0, '0, '1, '1, 1'b1, 3'd5, 8'h21, 3'd2, "R10");
        rd(3'd2, '1, '1, "R10");
        rd(3'd4, '1, '1, "R10");

        // R11: zero write has no effect, then clear channel 2
        step('0, 8'h10, '1, '1, 1'b1, 3'd6, 8'h00, 3'd4, "R11");
        step('0, '0, '1, '1, 1'b1, 3'd6, 8'h04, 3'd4, "R11");
        rd(3'd4, '1, '1, "R11");
        rd(3'd2, '1, '1, "R11");
        step('0, '0, '1, '1, 1'b1, 3'd5, 8'hFF, 3'd2, "R10");

        // R12: event and clear collide on the same bit
        step(8'h08, '0, '1, '1, 1'b0, 3'd0, '0, 3'd4, "R12");
        step(8'h08, '0, '1, '1, 1'b1, 3'd6, 8'h08, 3'd4, "R12");
        rd(3'd4, '1, '1, "R12");
        step('0, 8'h40, '1, '1, 1'b1, 3'd5, 8'h40, 3'd2, "R12");
        rd(3'd2, '1, '1, "R12");

        // R13: clear addresses and the spare address read zero
        rd(3'd5, '1, '1, "R13");
        rd(3'd6, '1, '1, "R13");
        rd(3'd7, '1, '1, "R13");

        // mixed pattern across channels with partial masks
        step(8'hA5, 8'h5A, 8'h0F, 8'hF0, 1'b0, 3'd0, '0, 3'd0, "R5");
        for (int a = 0; a < 5; a++) rd(a[2:0], 8'h0F, 8'hF0, "R9");
        rd(3'd0, 8'hF0, 8'h0F, "R9");

        // R8: masking everything drops all lines
        rd(3'd0, '0, '0, "R8");
        rd(3'd4, '0, 8'h10, "R8");
        rd(3'd3, 8'h20, '0, "R8");

        rd(3'd0, '0, '0, "R8");
        repeat (2) @(negedge clk);
        if (q.size() != 0) begin
            errors++;
            $display("FAIL R13 queue: got %0d pending expected 0", q.size());
        end
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule